// File: doc/BRIEF.md
# Three-Wire Serial Memory Slave Front-End

This block is the command side of a serial memory slave: a host selects it with `sel`, clocks in a start bit, then an opcode, an address and, for a write, a data word. All bits are sampled on rising `ser_clk` edges. A read returns the addressed word on `ser_out`, most significant bit first. A write, an erase or a protection change starts a self-timed program cycle. The program cycle is a counter on the system clock, and it finishes whatever `sel` does during it.

Between commands the host can check whether the device is still programming. It drops `sel` for a while and then raises it again. While the cycle is running, `ser_out` is driven low. Once the cycle has ended, it is driven high. A protection guard keeps words at or above a boundary address from being written. The guard can be removed only by a two-step sequence, and only once. The storage is a 256 x 8 register file inside the block.

Top module: `tw_mem_slave`

## Requirements
- R1: After reset, `ser_out_en` is 0, every memory word reads 0x00, and the protection boundary reads 0xFF.
- R2: While `sel` is high and no command has started, rising `ser_clk` edges with `ser_in` = 0 change nothing. The first edge that samples `ser_in` = 1 is the start bit.
- R3: After the start bit, the block takes 2 opcode bits and then 8 address bits, each most significant bit first. A write (`prot_mode` = 0, opcode 01) then takes 8 data bits, also most significant bit first.
- R4: A read (`prot_mode` = 0, opcode 10) drives `ser_out_en` = 1 and `ser_out` = 0 right after the last address edge. Each of the next 8 rising edges presents the next data bit, from bit 7 down to bit 0. The 9th edge releases `ser_out_en`.
- R5: A write stores its data word, and an erase (`prot_mode` = 0, opcode 11) stores 0xFF. Both need `prog_en` = 1. Without it, no program cycle starts and the memory is unchanged.
- R6: A program cycle lasts PROG_CYCLES system clocks. The memory or register update happens at its end, and the cycle completes even if `sel` falls.
- R7: When `sel` rises after a low period while a cycle is running, `ser_out_en` = 1 with `ser_out` = 0 until the cycle ends, then `ser_out` = 1. This status output stops when `sel` falls or a start bit is taken.
- R8: If `sel` stays high, or stays low, for the whole program cycle, `ser_out_en` stays 0.
- R9: `sel` low aborts a partly received command. Once a command has been fully received, further edges are ignored until `sel` goes low.
- R10: While a program cycle runs, no start bit is accepted.
- R11: A write or erase to an address at or above the boundary is rejected while the guard is in place. With `prot_mode` = 1 and `prog_en` = 1, opcode 01 sets the boundary to the address field through a program cycle. With `prot_mode` = 1, opcode 10 reads the boundary.
- R12: With `prot_mode` = 1, opcode 11 arms the unlock. Opcode 00 with address 0x00 and `prog_en` = 1 removes the guard through a program cycle. It does so only if the arm was the immediately preceding command and the guard has never been removed before. Any later unlock is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Device select, active high |
| ser_clk | input | 1 | Serial bit clock, sampled on rising edges |
| ser_in | input | 1 | Serial command, address and data input |
| prog_en | input | 1 | Permits programming commands |
| prot_mode | input | 1 | Selects the protection command set |
| ser_out | output | 1 | Read data or ready/busy level |
| ser_out_en | output | 1 | High when `ser_out` is driven, low for high-impedance |

## Verification
Reads and writes use several data patterns: 0xA5, 0x3C, 0x96 and 0x81. A dropped or reordered bit therefore gives a different value on read-back. Some frames are preceded by idle zero edges, cut off part way, or followed by extra edges. These tell a correct start-bit and frame count apart from off-by-one framing. Status probes are taken during the cycle and after it. They also cover `sel` held high and held low throughout, which separates the re-select status rule from plain busy reporting. The protection tests reach the boundary edge addresses. They also try an unlock with a non-adjacent arm, with a nonzero address, and a second unlock, so each rejection path is visible on its own.

// File: rtl/tw_pkg.sv
package tw_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;
    localparam int OP_W   = 2;

    localparam logic [OP_W-1:0] OPC_NOP   = 2'b00;
    localparam logic [OP_W-1:0] OPC_WRITE = 2'b01;
    localparam logic [OP_W-1:0] OPC_READ  = 2'b10;
    localparam logic [OP_W-1:0] OPC_ERASE = 2'b11;

    typedef enum logic [2:0] {
        PH_IDLE, PH_OPC, PH_ADDR, PH_DIN, PH_DOUT, PH_DONE
    } phase_e;

    typedef enum logic [1:0] {
        PK_WORD, PK_BOUND, PK_UNLOCK
    } prog_kind_e;

    typedef struct packed {
        prog_kind_e          kind;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   data;
    } prog_req_t;

    function automatic logic word_open(input logic [ADDR_W-1:0] a,
                                       input logic [ADDR_W-1:0] limit,
                                       input logic unlocked);
        return unlocked || (a < limit);
    endfunction
endpackage

// File: rtl/tw_cmd_fsm.sv
module tw_cmd_fsm
    import tw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              ser_clk,
    input  logic              ser_in,
    input  logic              prog_en,
    input  logic              prot_mode,
    input  logic              busy,
    input  logic              otp,
    input  logic [ADDR_W-1:0] boundary,
    input  logic [DATA_W-1:0] mem_word,
    output logic [ADDR_W-1:0] look_addr,
    output logic              launch,
    output prog_req_t         launch_req,
    output logic              out_active,
    output logic              out_bit,
    output logic              cmd_active,
    output phase_e            phase_o
);
    localparam int CNT_W = $clog2(DATA_W + 2);

    phase_e             phase;
    logic               sclk_q;
    logic [CNT_W-1:0]   cnt;
    logic [OP_W-1:0]    op_sh;
    logic [ADDR_W-1:0]  addr_sh;
    logic [DATA_W-2:0]  data_sh;
    logic [DATA_W:0]    out_sh;
    logic               armed;
    logic               rise;
    logic [ADDR_W-1:0]  nxt_addr;
    logic [DATA_W-1:0]  nxt_data;

    assign rise      = ser_clk & ~sclk_q;
    assign nxt_addr  = {addr_sh[ADDR_W-2:0], ser_in};
    assign nxt_data  = {data_sh, ser_in};
    assign look_addr = nxt_addr;

    assign out_active = (phase == PH_DOUT);
    assign out_bit    = out_sh[DATA_W];
    assign cmd_active = (phase != PH_IDLE);
    assign phase_o    = phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= PH_IDLE;
            sclk_q     <= 1'b0;
            cnt        <= '0;
            op_sh      <= '0;
            addr_sh    <= '0;
            data_sh    <= '0;
            out_sh     <= '0;
            armed      <= 1'b0;
            launch     <= 1'b0;
            launch_req <= '0;
        end else begin
            sclk_q <= ser_clk;
            launch <= 1'b0;
            if (!sel) begin
                phase <= PH_IDLE;
                cnt   <= '0;
            end else if (rise) begin
                case (phase)
                    PH_IDLE: begin
                        if (ser_in && !busy) begin
                            phase <= PH_OPC;
                            cnt   <= '0;
                        end
                    end
                    PH_OPC: begin
                        op_sh <= {op_sh[0], ser_in};
                        if (cnt == CNT_W'(OP_W - 1)) begin
                            phase <= PH_ADDR;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    PH_ADDR: begin
                        addr_sh <= nxt_addr;
                        if (cnt != CNT_W'(ADDR_W - 1)) begin
                            cnt <= cnt + 1'b1;
                        end else begin
                            cnt   <= '0;
                            armed <= prot_mode && (op_sh == OPC_ERASE);
                            phase <= PH_DONE;
                            if (!prot_mode) begin
                                case (op_sh)
                                    OPC_READ: begin
                                        out_sh <= {1'b0, mem_word};
                                        phase  <= PH_DOUT;
                                    end
                                    OPC_WRITE: phase <= PH_DIN;
                                    OPC_ERASE: begin
                                        if (prog_en && word_open(nxt_addr, boundary, otp)) begin
                                            launch          <= 1'b1;
                                            launch_req.kind <= PK_WORD;
                                            launch_req.addr <= nxt_addr;
                                            launch_req.data <= '1;
                                        end
                                    end
                                    default: ;
                                endcase
                            end else begin
                                case (op_sh)
                                    OPC_READ: begin
                                        out_sh <= {1'b0, boundary};
                                        phase  <= PH_DOUT;
                                    end
                                    OPC_WRITE: begin
                                        if (prog_en) begin
                                            launch          <= 1'b1;
                                            launch_req.kind <= PK_BOUND;
                                            launch_req.addr <= nxt_addr;
                                            launch_req.data <= '0;
                                        end
                                    end
                                    OPC_NOP: begin
                                        if (prog_en && armed && !otp && (nxt_addr == '0)) begin
                                            launch          <= 1'b1;
                                            launch_req.kind <= PK_UNLOCK;
                                            launch_req.addr <= '0;
                                            launch_req.data <= '0;
                                        end
                                    end
                                    default: ;
                                endcase
                            end
                        end
                    end
                    PH_DIN: begin
                        data_sh <= nxt_data[DATA_W-2:0];
                        if (cnt != CNT_W'(DATA_W - 1)) begin
                            cnt <= cnt + 1'b1;
                        end else begin
                            cnt   <= '0;
                            phase <= PH_DONE;
                            if (prog_en && word_open(addr_sh, boundary, otp)) begin
                                launch          <= 1'b1;
                                launch_req.kind <= PK_WORD;
                                launch_req.addr <= addr_sh;
                                launch_req.data <= nxt_data;
                            end
                        end
                    end
                    PH_DOUT: begin
                        out_sh <= {out_sh[DATA_W-1:0], 1'b0};
                        if (cnt == CNT_W'(DATA_W)) begin
                            phase <= PH_DONE;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/tw_prog_timer.sv
module tw_prog_timer
    import tw_pkg::*;
#(
    parameter int PROG_CYCLES = 40
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      launch,
    input  prog_req_t launch_req,
    output logic      busy,
    output logic      commit,
    output prog_req_t commit_req
);
    localparam int CW = $clog2(PROG_CYCLES + 1);

    logic [CW-1:0] cnt;
    prog_req_t     req_q;

    assign busy       = (cnt != '0);
    assign commit     = (cnt == CW'(1));
    assign commit_req = req_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            req_q <= '0;
        end else if (launch && !busy) begin
            cnt   <= CW'(PROG_CYCLES);
            req_q <= launch_req;
        end else if (busy) begin
            cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/tw_store.sv
module tw_store
    import tw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              commit,
    input  prog_req_t         commit_req,
    input  logic [ADDR_W-1:0] look_addr,
    output logic [DATA_W-1:0] mem_word,
    output logic [ADDR_W-1:0] boundary,
    output logic              otp
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    assign mem_word = mem[look_addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            boundary <= '1;
            otp      <= 1'b0;
        end else if (commit) begin
            case (commit_req.kind)
                PK_WORD:   mem[commit_req.addr] <= commit_req.data;
                PK_BOUND:  boundary <= commit_req.addr;
                PK_UNLOCK: otp <= 1'b1;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/tw_mem_slave.sv
module tw_mem_slave
    import tw_pkg::*;
#(
    parameter int PROG_CYCLES = 40
) (
    input  logic clk,
    input  logic rst,
    input  logic sel,
    input  logic ser_clk,
    input  logic ser_in,
    input  logic prog_en,
    input  logic prot_mode,
    output logic ser_out,
    output logic ser_out_en
);
    logic              busy;
    logic              commit;
    logic              launch;
    prog_req_t         launch_req;
    prog_req_t         commit_req;
    logic [ADDR_W-1:0] look_addr;
    logic [DATA_W-1:0] mem_word;
    logic [ADDR_W-1:0] boundary;
    logic              otp;
    logic              out_active;
    logic              out_bit;
    logic              cmd_active;
    phase_e            cmd_phase;
    logic              sel_q;
    logic              stat_mode;

    tw_cmd_fsm fsm_i (
        .clk(clk), .rst(rst), .sel(sel), .ser_clk(ser_clk), .ser_in(ser_in),
        .prog_en(prog_en), .prot_mode(prot_mode), .busy(busy), .otp(otp),
        .boundary(boundary), .mem_word(mem_word), .look_addr(look_addr),
        .launch(launch), .launch_req(launch_req), .out_active(out_active),
        .out_bit(out_bit), .cmd_active(cmd_active), .phase_o(cmd_phase)
    );

    tw_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) timer_i (
        .clk(clk), .rst(rst), .launch(launch), .launch_req(launch_req),
        .busy(busy), .commit(commit), .commit_req(commit_req)
    );

    tw_store store_i (
        .clk(clk), .rst(rst), .commit(commit), .commit_req(commit_req),
        .look_addr(look_addr), .mem_word(mem_word), .boundary(boundary), .otp(otp)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q     <= 1'b0;
            stat_mode <= 1'b0;
        end else begin
            sel_q <= sel;
            if (!sel || cmd_active)
                stat_mode <= 1'b0;
            else if (!sel_q && busy)
                stat_mode <= 1'b1;
        end
    end

    assign ser_out_en = out_active | (stat_mode & sel);
    assign ser_out    = out_active ? out_bit : ~busy;
endmodule

// File: rtl/tw_mem_slave_chk.sv
module tw_mem_slave_chk
    import tw_pkg::*;
#(
    parameter int PROG_CYCLES = 40
) (
    input logic   clk,
    input logic   rst,
    input logic   sel,
    input logic   busy,
    input logic   launch,
    input logic   commit,
    input logic   otp,
    input logic   ser_out_en,
    input phase_e cmd_phase
);
    int busy_len;

    always_ff @(posedge clk) begin
        if (rst)       busy_len <= 0;
        else if (busy) busy_len <= busy_len + 1;
        else           busy_len <= 0;
    end

    assert_cycle_len_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (busy_len == PROG_CYCLES));

    assert_commit_ends_R6: assert property (@(posedge clk) disable iff (rst)
        commit |=> !busy);

    assert_idle_after_deselect_R9: assert property (@(posedge clk) disable iff (rst)
        !sel |=> (cmd_phase == PH_IDLE));

    assert_no_launch_busy_R10: assert property (@(posedge clk) disable iff (rst)
        launch |-> !busy);

    assert_quiet_unselected_R8: assert property (@(posedge clk) disable iff (rst)
        !sel |=> !ser_out_en);

    assert_unlock_sticky_R12: assert property (@(posedge clk) disable iff (rst)
        otp |=> otp);
endmodule

bind tw_mem_slave tw_mem_slave_chk #(.PROG_CYCLES(PROG_CYCLES)) chk_i (
    .clk(clk), .rst(rst), .sel(sel), .busy(busy), .launch(launch),
    .commit(commit), .otp(otp), .ser_out_en(ser_out_en), .cmd_phase(cmd_phase)
);

// File: tb/tw_mem_slave_tb.sv
module tw_mem_slave_tb_top;
    localparam int PROG = 60;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sel = 1'b0;
    logic ser_clk = 1'b0;
    logic ser_in = 1'b0;
    logic prog_en = 1'b0;
    logic prot_mode = 1'b0;
    logic ser_out;
    logic ser_out_en;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    tw_mem_slave #(.PROG_CYCLES(PROG)) dut_i (
        .clk(clk), .rst(rst), .sel(sel), .ser_clk(ser_clk), .ser_in(ser_in),
        .prog_en(prog_en), .prot_mode(prot_mode), .ser_out(ser_out),
        .ser_out_en(ser_out_en)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input logic b);
        ser_in = b;
        tick(1);
        ser_clk = 1'b1;
        tick(2);
        ser_clk = 1'b0;
        tick(2);
    endtask

    task automatic shift(input logic [15:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) pulse(v[i]);
    endtask

    task automatic deselect();
        sel = 1'b0;
        ser_clk = 1'b0;
        ser_in = 1'b0;
        tick(3);
    endtask

    task automatic head(input logic [1:0] op, input logic [7:0] addr,
                        input logic pm, input logic pg);
        prot_mode = pm;
        prog_en = pg;
        sel = 1'b1;
        tick(1);
        pulse(1'b1);
        shift({14'd0, op}, 2);
        shift({8'd0, addr}, 8);
    endtask

    task automatic read_word(input logic pm, input logic [7:0] addr, output logic [7:0] d);
        head(2'b10, addr, pm, 1'b0);
        chk("R4 dummy zero", {30'd0, ser_out_en, ser_out}, 32'h2);
        for (int i = 7; i >= 0; i--) begin
            pulse(1'b0);
            d[i] = ser_out;
            chk("R4 driven", {31'd0, ser_out_en}, 32'd1);
        end
        pulse(1'b0);
        chk("R4 release", {31'd0, ser_out_en}, 32'd0);
        deselect();
    endtask

    task automatic write_word(input logic [7:0] addr, input logic [7:0] data, input logic pg);
        head(2'b01, addr, 1'b0, pg);
        shift({8'd0, data}, 8);
    endtask

    task automatic probe(output logic seen);
        deselect();
        sel = 1'b1;
        tick(2);
        seen = ser_out_en && !ser_out;
        deselect();
    endtask

    task automatic settle();
        deselect();
        tick(PROG + 10);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R1 released", {31'd0, ser_out_en}, 32'd0);
        read_word(1'b0, 8'h10, d);
        chk("R1 mem zero", {24'd0, d}, 32'h00);
        read_word(1'b1, 8'h00, d);
        chk("R1 boundary", {24'd0, d}, 32'hFF);
    endtask

    task automatic t_write_read();
        logic [7:0] d;
        logic b;
        write_word(8'h12, 8'hA5, 1'b1);
        probe(b);
        chk("R6 busy after write", {31'd0, b}, 32'd1);
        settle();
        read_word(1'b0, 8'h12, d);
        chk("R3 readback A5", {24'd0, d}, 32'hA5);
        write_word(8'h34, 8'h3C, 1'b1);
        settle();
        read_word(1'b0, 8'h34, d);
        chk("R3 readback 3C", {24'd0, d}, 32'h3C);
        read_word(1'b0, 8'h12, d);
        chk("R3 other word kept", {24'd0, d}, 32'hA5);
        head(2'b11, 8'h12, 1'b0, 1'b1);
        settle();
        read_word(1'b0, 8'h12, d);
        chk("R5 erase to FF", {24'd0, d}, 32'hFF);
    endtask

    task automatic t_prog_off();
        logic [7:0] d;
        logic b;
        write_word(8'h20, 8'h77, 1'b0);
        probe(b);
        chk("R5 no cycle without enable", {31'd0, b}, 32'd0);
        settle();
        read_word(1'b0, 8'h20, d);
        chk("R5 word unchanged", {24'd0, d}, 32'h00);
    endtask

    task automatic t_status();
        logic [7:0] d;
        write_word(8'h40, 8'h81, 1'b1);
        deselect();
        sel = 1'b1;
        tick(2);
        chk("R7 busy level", {30'd0, ser_out_en, ser_out}, 32'h2);
        for (int i = 0; i < 5; i++) pulse(1'b1);
        chk("R10 start ignored while busy", {30'd0, ser_out_en, ser_out}, 32'h2);
        tick(PROG + 5);
        chk("R7 ready level", {30'd0, ser_out_en, ser_out}, 32'h3);
        deselect();
        chk("R7 cleared on deselect", {31'd0, ser_out_en}, 32'd0);
        read_word(1'b0, 8'h40, d);
        chk("R6 status write landed", {24'd0, d}, 32'h81);
    endtask

    task automatic t_hold();
        logic [7:0] d;
        write_word(8'h50, 8'h5A, 1'b1);
        tick(5);
        chk("R8 held high early", {31'd0, ser_out_en}, 32'd0);
        tick(PROG);
        chk("R8 held high late", {31'd0, ser_out_en}, 32'd0);
        deselect();
        read_word(1'b0, 8'h50, d);
        chk("R8 write landed", {24'd0, d}, 32'h5A);
        write_word(8'h51, 8'hC3, 1'b1);
        deselect();
        tick(10);
        chk("R8 held low", {31'd0, ser_out_en}, 32'd0);
        tick(PROG);
        read_word(1'b0, 8'h51, d);
        chk("R6 completes with select low", {24'd0, d}, 32'hC3);
    endtask

    task automatic t_abort();
        logic [7:0] d;
        prot_mode = 1'b0;
        prog_en = 1'b1;
        sel = 1'b1;
        tick(1);
        pulse(1'b1);
        shift(16'h0001, 2);
        shift(16'h000F, 4);
        deselect();
        write_word(8'h60, 8'h96, 1'b1);
        settle();
        read_word(1'b0, 8'h60, d);
        chk("R9 abort then write", {24'd0, d}, 32'h96);
        head(2'b10, 8'h60, 1'b0, 1'b1);
        for (int i = 0; i < 9; i++) pulse(1'b0);
        pulse(1'b1);
        shift(16'h0001, 2);
        shift(16'h0060, 8);
        shift(16'h0000, 8);
        settle();
        read_word(1'b0, 8'h60, d);
        chk("R9 trailing frame ignored", {24'd0, d}, 32'h96);
    endtask

    task automatic t_start();
        logic [7:0] d;
        prot_mode = 1'b0;
        prog_en = 1'b0;
        sel = 1'b1;
        tick(1);
        for (int i = 0; i < 6; i++) pulse(1'b0);
        chk("R2 idle zeros", {31'd0, ser_out_en}, 32'd0);
        pulse(1'b1);
        shift(16'h0002, 2);
        shift(16'h0060, 8);
        for (int i = 7; i >= 0; i--) begin
            pulse(1'b0);
            d[i] = ser_out;
        end
        chk("R2 read after idle edges", {24'd0, d}, 32'h96);
        deselect();
    endtask

    task automatic t_protect();
        logic [7:0] d;
        logic b;
        write_word(8'hFF, 8'h11, 1'b1);
        probe(b);
        chk("R11 top word guarded", {31'd0, b}, 32'd0);
        settle();
        read_word(1'b0, 8'hFF, d);
        chk("R11 top word unchanged", {24'd0, d}, 32'h00);
        head(2'b01, 8'h80, 1'b1, 1'b1);
        settle();
        read_word(1'b1, 8'h00, d);
        chk("R11 boundary set", {24'd0, d}, 32'h80);
        write_word(8'h90, 8'h22, 1'b1);
        settle();
        read_word(1'b0, 8'h90, d);
        chk("R11 above boundary rejected", {24'd0, d}, 32'h00);
        write_word(8'h80, 8'h23, 1'b1);
        settle();
        read_word(1'b0, 8'h80, d);
        chk("R11 at boundary rejected", {24'd0, d}, 32'h00);
        write_word(8'h7F, 8'h33, 1'b1);
        settle();
        read_word(1'b0, 8'h7F, d);
        chk("R11 below boundary written", {24'd0, d}, 32'h33);
        head(2'b01, 8'h20, 1'b1, 1'b0);
        settle();
        read_word(1'b1, 8'h00, d);
        chk("R11 boundary needs enable", {24'd0, d}, 32'h80);
    endtask

    task automatic t_unlock();
        logic [7:0] d;
        logic b;
        head(2'b11, 8'h00, 1'b1, 1'b0);
        deselect();
        read_word(1'b0, 8'h7F, d);
        head(2'b00, 8'h00, 1'b1, 1'b1);
        probe(b);
        chk("R12 arm not adjacent", {31'd0, b}, 32'd0);
        head(2'b11, 8'h00, 1'b1, 1'b0);
        deselect();
        head(2'b00, 8'h05, 1'b1, 1'b1);
        probe(b);
        chk("R12 nonzero address", {31'd0, b}, 32'd0);
        settle();
        write_word(8'h90, 8'h44, 1'b1);
        settle();
        read_word(1'b0, 8'h90, d);
        chk("R12 still guarded", {24'd0, d}, 32'h00);
        head(2'b11, 8'h00, 1'b1, 1'b0);
        deselect();
        head(2'b00, 8'h00, 1'b1, 1'b1);
        probe(b);
        chk("R12 unlock accepted", {31'd0, b}, 32'd1);
        settle();
        write_word(8'h90, 8'h44, 1'b1);
        settle();
        read_word(1'b0, 8'h90, d);
        chk("R12 guard removed", {24'd0, d}, 32'h44);
        head(2'b11, 8'h00, 1'b1, 1'b0);
        deselect();
        head(2'b00, 8'h00, 1'b1, 1'b1);
        probe(b);
        chk("R12 one time only", {31'd0, b}, 32'd0);
        settle();
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        tick(5);
        rst = 1'b0;
        tick(2);
        t_reset();
        t_write_read();
        t_prog_off();
        t_status();
        t_hold();
        t_abort();
        t_start();
        t_protect();
        t_unlock();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule